// File: doc/BRIEF.md
# Dual-Row Clock Configuration Store with Shadow

This block holds the setup word of a crystal-based clock synthesizer. The word carries the feedback count, the reference count, a post-divider code, a divider-source bit, a seven-bit crystal-load trim code, a duty-level bit and two power-control bits. Words arrive over a bit-serial port and land in a rewritable shadow register. A commit strobe then burns the shadow into one of two write-once rows. The shadow drives the synthesizer while no permanent row is valid, so the output frequency can be measured and trimmed as often as needed before anything is burned.

A strap picks one of two uses for the second row. In reprogram mode it is a single spare slot that replaces row 0 once it is burned. In frequency-select mode it holds an alternate configuration, and a select pin chooses between the two rows, so the spare slot is not available. A second strap models the variant with the shadow disabled: only burned rows may then drive the outputs. Rows are cleared only by a separate erase input, which models the blank state of a fresh part. The ordinary reset clears the shadow and leaves burned rows intact.

Top module: `clkcfg_store`

## Requirements
- R1: While `erase_n` is low, both rows become blank: zero data, valid clear. While `rst_n` is low, the shadow and the serial register are cleared and the burned rows are kept. With nothing burned and the shadow enabled, every configuration output is zero after reset, `active_src` is 0 and `burn_err` is 0.
- R2: Each cycle with `ser_shift` high shifts `ser_data` into a 36-bit register, MSB first. A cycle with `ser_load` high copies that register into the shadow. The shadow may be reloaded any number of times. Field positions, from MSB down: [35:24] feedback, [23:14] reference, [13:11] post-divider, [10] divider source, [9:3] trim code, [2] duty level, [1] power mode, [0] power timing.
- R3: A burned row never changes. Once row 0 is valid in reprogram mode, later shadow loads have no effect on the outputs.
- R4: A `commit` pulse copies the shadow into row 0 if row 0 is blank, and otherwise into row 1 if row 1 is blank. It sets that row's valid bit. At most one row is written per pulse.
- R5: A `commit` while both rows are valid changes nothing. It raises `burn_err` for exactly one cycle.
- R6: In reprogram mode (`strap_fsel`=0), the active source has this priority: valid row 1 first, then valid row 0, then the shadow.
- R7: With `strap_no_shadow`=1, the shadow never becomes the active source. With no usable row, all configuration outputs are zero and `active_src` is 3.
- R8: In frequency-select mode (`strap_fsel`=1), `row_sel`=0 selects row 0 and `row_sel`=1 selects row 1. If the selected row is blank, the shadow is used instead (or blank, under R7).
- R9: `active_src` encodes the source of the outputs: 0 shadow, 1 row 0, 2 row 1, 3 blank. The outputs and `active_src` are registered. They update on the clock edge after the edge that changes any stored state or strap.
- R10: The trim code reaches `tune_code` unchanged over its whole range 0 to 127. Larger codes mean more load capacitance and therefore a lower frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low async reset of shadow and control |
| erase_n | input | 1 | Active-low async blanking of both rows |
| strap_fsel | input | 1 | 1 = frequency-select mode, 0 = reprogram mode |
| strap_no_shadow | input | 1 | 1 = shadow may never drive outputs |
| row_sel | input | 1 | Row choice in frequency-select mode |
| ser_data | input | 1 | Serial configuration bit |
| ser_shift | input | 1 | Shift enable for the serial register |
| ser_load | input | 1 | Copy serial register into shadow |
| commit | input | 1 | Burn shadow into first blank row |
| fb_count | output | 12 | Active feedback count |
| ref_count | output | 10 | Active reference count |
| post_div | output | 3 | Active post-divider code |
| div_from_ref | output | 1 | 1 = divider fed from the reference oscillator |
| tune_code | output | 7 | Active crystal-load trim code |
| duty_cmos | output | 1 | 1 = CMOS duty level, 0 = TTL |
| pwr_down_mode | output | 1 | 1 = power-down, 0 = output-enable |
| pwr_sync | output | 1 | 1 = synchronous power control timing |
| row_valid | output | 2 | Valid bits of row 1 and row 0 |
| active_src | output | 2 | Source of the outputs (R9) |
| burn_err | output | 1 | One-cycle pulse on a commit with no blank row |

## Verification
The serial path is swept over all 128 trim codes. Each word also carries a distinct feedback, reference, divider and flag pattern, so a swapped, shifted or truncated field shows up as a mismatch on the whole word. Four further words with dissimilar bit patterns are burned and loaded, so it is always clear which of shadow, row 0 and row 1 is driving the outputs. These words go through both strap modes, both `row_sel` values, the shadow-disabled strap, a reset with rows preserved, and a commit with both rows full.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int unsigned FB_W     = 12;
  localparam int unsigned REF_W    = 10;
  localparam int unsigned PDIV_W   = 3;
  localparam int unsigned TUNE_W   = 7;
  localparam int unsigned FLAG_W   = 4;  // divider source, duty, power mode, power timing
  localparam int unsigned CFG_W    = FB_W + REF_W + PDIV_W + TUNE_W + FLAG_W;
  localparam int unsigned NUM_ROWS = 2;
  localparam int unsigned SCNT_W   = $clog2(CFG_W + 1);

  typedef struct packed {
    logic [FB_W-1:0]   fb;
    logic [REF_W-1:0]  refc;
    logic [PDIV_W-1:0] pdiv;
    logic              dsrc;
    logic [TUNE_W-1:0] tune;
    logic              duty_cmos;
    logic              pwr_pd;
    logic              pwr_sync;
  } cfg_t;

  typedef enum logic [1:0] {
    SRC_SHADOW = 2'd0,
    SRC_ROW0   = 2'd1,
    SRC_ROW1   = 2'd2,
    SRC_BLANK  = 2'd3
  } src_e;

  // Source choice for the active word
  function automatic src_e pick_src(input logic fsel, input logic rsel,
                                    input logic v0, input logic v1,
                                    input logic shadow_on);
    src_e s;
    if (fsel) begin
      if (rsel && v1)        s = SRC_ROW1;
      else if (!rsel && v0)  s = SRC_ROW0;
      else if (shadow_on)    s = SRC_SHADOW;
      else                   s = SRC_BLANK;
    end else begin
      if (v1)                s = SRC_ROW1;
      else if (v0)           s = SRC_ROW0;
      else if (shadow_on)    s = SRC_SHADOW;
      else                   s = SRC_BLANK;
    end
    return s;
  endfunction

  // One-hot mask of the lowest blank row; zero when all rows are burned
  function automatic logic [NUM_ROWS-1:0] first_blank(input logic [NUM_ROWS-1:0] valid);
    logic [NUM_ROWS-1:0] m;
    logic                hit;
    m   = '0;
    hit = 1'b0;
    for (int i = 0; i < NUM_ROWS; i++) begin
      if (!hit && !valid[i]) begin
        m[i] = 1'b1;
        hit  = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/clkcfg_shadow.sv
module clkcfg_shadow
  import clkcfg_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_data,
  input  logic         ser_shift,
  input  logic         ser_load,
  output logic [W-1:0] shadow_q
);

  logic [W-1:0] sreg_q;
  logic         load_evt;

  assign load_evt = ser_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (ser_shift) begin
      sreg_q <= {sreg_q[W-2:0], ser_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (load_evt) begin
      shadow_q <= sreg_q;
    end
  end

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> shadow_q == $past(sreg_q)); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(shadow_q)); // R2

endmodule

// File: rtl/clkcfg_otp_row.sv
module clkcfg_otp_row
  import clkcfg_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         erase_n,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] data_q,
  output logic         valid_q
);

  logic burn_evt;

  assign burn_evt = wr_en && !valid_q;

  always_ff @(posedge clk or negedge erase_n) begin
    if (!erase_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (burn_evt) begin
      data_q  <= din;
      valid_q <= 1'b1;
    end
  end

  AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!erase_n)
    valid_q |=> valid_q && $stable(data_q)); // R3
  AST_ROW_NO_REBURN: assert property (@(posedge clk) disable iff (!erase_n)
    wr_en |-> !valid_q); // R3
  AST_ROW_CAPTURE: assert property (@(posedge clk) disable iff (!erase_n)
    burn_evt |=> valid_q && data_q == $past(din)); // R4

endmodule

// File: rtl/clkcfg_burn.sv
module clkcfg_burn
  import clkcfg_pkg::*;
#(
  parameter int unsigned ROWS = NUM_ROWS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [ROWS-1:0] valid,
  output logic [ROWS-1:0] wr_en,
  output logic            burn_err
);

  logic [ROWS-1:0] target;
  logic            all_full;
  logic            reject_evt;

  assign target     = first_blank(valid);
  assign all_full   = (target == '0);
  assign wr_en      = commit ? target : '0;
  assign reject_evt = commit && all_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burn_err <= 1'b0;
    else        burn_err <= reject_evt;
  end

  AST_BURN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R4
  AST_BURN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[1] |-> valid[0]); // R4
  AST_FULL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (&valid) |=> burn_err); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    burn_err |-> $past(commit)); // R5

endmodule

// File: rtl/clkcfg_select.sv
module clkcfg_select
  import clkcfg_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fsel,
  input  logic         rsel,
  input  logic         no_shadow,
  input  logic [W-1:0] shadow,
  input  logic [W-1:0] row0,
  input  logic [W-1:0] row1,
  input  logic         v0,
  input  logic         v1,
  output logic [W-1:0] act_q,
  output src_e         src_q
);

  src_e         src_nxt;
  logic [W-1:0] word_nxt;

  always_comb begin
    src_nxt = pick_src(fsel, rsel, v0, v1, !no_shadow);
    unique case (src_nxt)
      SRC_SHADOW: word_nxt = shadow;
      SRC_ROW0:   word_nxt = row0;
      SRC_ROW1:   word_nxt = row1;
      default:    word_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      src_q <= SRC_BLANK;
    end else begin
      act_q <= word_nxt;
      src_q <= src_nxt;
    end
  end

  AST_NO_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    no_shadow |=> src_q != SRC_SHADOW); // R7
  AST_ROW1_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    !fsel && v1 |=> src_q == SRC_ROW1); // R6
  AST_FSEL_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
    fsel && !rsel && v0 |=> src_q == SRC_ROW0 && act_q == $past(row0)); // R8
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    src_q == SRC_BLANK |-> act_q == '0); // R7

endmodule

// File: rtl/clkcfg_store.sv
module clkcfg_store
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_n,
  input  logic              strap_fsel,
  input  logic              strap_no_shadow,
  input  logic              row_sel,
  input  logic              ser_data,
  input  logic              ser_shift,
  input  logic              ser_load,
  input  logic              commit,
  output logic [FB_W-1:0]   fb_count,
  output logic [REF_W-1:0]  ref_count,
  output logic [PDIV_W-1:0] post_div,
  output logic              div_from_ref,
  output logic [TUNE_W-1:0] tune_code,
  output logic              duty_cmos,
  output logic              pwr_down_mode,
  output logic              pwr_sync,
  output logic [1:0]        row_valid,
  output logic [1:0]        active_src,
  output logic              burn_err
);

  logic [CFG_W-1:0]    shadow_w;
  logic [CFG_W-1:0]    row_data [NUM_ROWS];
  logic [NUM_ROWS-1:0] row_v;
  logic [NUM_ROWS-1:0] row_wr;
  logic [CFG_W-1:0]    act_w;
  src_e                src_w;
  cfg_t                act_s;

  clkcfg_shadow #(.W(CFG_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_data  (ser_data),
    .ser_shift (ser_shift),
    .ser_load  (ser_load),
    .shadow_q  (shadow_w)
  );

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    clkcfg_otp_row #(.W(CFG_W)) u_row (
      .clk     (clk),
      .erase_n (erase_n),
      .wr_en   (row_wr[g]),
      .din     (shadow_w),
      .data_q  (row_data[g]),
      .valid_q (row_v[g])
    );
  end

  clkcfg_burn #(.ROWS(NUM_ROWS)) u_burn (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .valid    (row_v),
    .wr_en    (row_wr),
    .burn_err (burn_err)
  );

  clkcfg_select #(.W(CFG_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsel      (strap_fsel),
    .rsel      (row_sel),
    .no_shadow (strap_no_shadow),
    .shadow    (shadow_w),
    .row0      (row_data[0]),
    .row1      (row_data[1]),
    .v0        (row_v[0]),
    .v1        (row_v[1]),
    .act_q     (act_w),
    .src_q     (src_w)
  );

  assign act_s         = cfg_t'(act_w);
  assign fb_count      = act_s.fb;
  assign ref_count     = act_s.refc;
  assign post_div      = act_s.pdiv;
  assign div_from_ref  = act_s.dsrc;
  assign tune_code     = act_s.tune;
  assign duty_cmos     = act_s.duty_cmos;
  assign pwr_down_mode = act_s.pwr_pd;
  assign pwr_sync      = act_s.pwr_sync;
  assign row_valid     = row_v;
  assign active_src    = src_w;

  AST_SHADOW_SRC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    src_w == SRC_SHADOW && !$past(ser_load) && !$past(ser_load, 2) |-> act_w == shadow_w); // R2

endmodule

// File: tb/clkcfg_store_tb.sv
module clkcfg_store_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0, erase_n = 1'b0;
  logic strap_fsel = 1'b0, strap_no_shadow = 1'b0, row_sel = 1'b0;
  logic ser_data = 1'b0, ser_shift = 1'b0, ser_load = 1'b0, commit = 1'b0;
  logic [11:0] fb_count;
  logic [9:0]  ref_count;
  logic [2:0]  post_div;
  logic        div_from_ref, duty_cmos, pwr_down_mode, pwr_sync, burn_err;
  logic [6:0]  tune_code;
  logic [1:0]  row_valid, active_src;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  clkcfg_store u_dut (
    .clk(clk), .rst_n(rst_n), .erase_n(erase_n),
    .strap_fsel(strap_fsel), .strap_no_shadow(strap_no_shadow), .row_sel(row_sel),
    .ser_data(ser_data), .ser_shift(ser_shift), .ser_load(ser_load), .commit(commit),
    .fb_count(fb_count), .ref_count(ref_count), .post_div(post_div),
    .div_from_ref(div_from_ref), .tune_code(tune_code), .duty_cmos(duty_cmos),
    .pwr_down_mode(pwr_down_mode), .pwr_sync(pwr_sync),
    .row_valid(row_valid), .active_src(active_src), .burn_err(burn_err)
  );

  localparam logic [35:0] WA = 36'h123456789;
  localparam logic [35:0] WB = 36'hFEDCBA987;
  localparam logic [35:0] WC = 36'h0F0F0F0F0;
  localparam logic [35:0] WD = 36'h5A5A5A5A5;

  function automatic logic [35:0] out_word();
    return {fb_count, ref_count, post_div, div_from_ref, tune_code,
            duty_cmos, pwr_down_mode, pwr_sync};
  endfunction

  // Sweep word: every field driven from the index by its own arithmetic
  function automatic logic [35:0] sweep_word(input int i);
    logic [11:0] fb;
    logic [9:0]  rf;
    logic [6:0]  tn;
    fb = 12'((i * 37 + 5) % 4096);
    rf = 10'((i * 13 + 1) % 1024);
    tn = 7'(i);
    return {fb, rf, 3'(i % 8), 1'((i / 8) % 2), tn, 1'((i / 16) % 2),
            1'((i / 32) % 2), 1'(((i % 2) + (i / 64)) % 2)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic load_shadow(input logic [35:0] w);
    for (int b = 35; b >= 0; b--) begin
      @(negedge clk);
      ser_shift = 1'b1;
      ser_data  = w[b];
    end
    @(negedge clk);
    ser_shift = 1'b0;
    ser_load  = 1'b1;
    @(negedge clk);
    ser_load  = 1'b0;
  endtask

  task automatic pulse_commit();
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    erase_n = 1'b1;
    rst_n   = 1'b1;
    settle();
    // R1: blank part after erase and reset
    check("R1 word", 64'(out_word()), 64'd0);
    check("R1 src", 64'(active_src), 64'd0);
    check("R1 valid", 64'(row_valid), 64'd0);
    check("R1 err", 64'(burn_err), 64'd0);

    // R7: shadow disabled, nothing burned -> blank
    strap_no_shadow = 1'b1;
    settle();
    check("R7 blank src", 64'(active_src), 64'd3);
    strap_no_shadow = 1'b0;

    // R2 / R10: sweep of all trim codes through the shadow
    for (int i = 0; i < 128; i++) begin
      load_shadow(sweep_word(i));
      settle();
      check("R10 tune", 64'(tune_code), 64'(i));
      check("R2 word", 64'(out_word()), 64'(sweep_word(i)));
    end
    check("R9 shadow src", 64'(active_src), 64'd0);

    // R4: first burn goes to row 0
    load_shadow(WA);
    pulse_commit();
    settle();
    check("R4 valid row0", 64'(row_valid), 64'd1);
    check("R9 row0 src", 64'(active_src), 64'd1);
    check("R4 row0 word", 64'(out_word()), 64'(WA));

    // R3: later shadow load has no effect on outputs
    load_shadow(WB);
    settle();
    check("R3 row0 kept", 64'(out_word()), 64'(WA));
    check("R3 row1 blank", 64'(row_valid), 64'd1);

    // R8: frequency-select with blank row 1 falls back to shadow
    strap_fsel = 1'b1;
    row_sel    = 1'b1;
    settle();
    check("R8 fallback src", 64'(active_src), 64'd0);
    check("R8 fallback word", 64'(out_word()), 64'(WB));
    strap_no_shadow = 1'b1;
    settle();
    check("R7 fsel blank src", 64'(active_src), 64'd3);
    check("R7 fsel blank word", 64'(out_word()), 64'd0);
    strap_no_shadow = 1'b0;
    row_sel = 1'b0;
    settle();
    check("R8 sel row0", 64'(out_word()), 64'(WA));

    // R1: reset keeps rows, clears shadow
    do_reset();
    check("R1 rows kept", 64'(row_valid), 64'd1);
    check("R1 row0 after rst", 64'(out_word()), 64'(WA));
    row_sel = 1'b1;
    settle();
    check("R1 shadow cleared", 64'(out_word()), 64'd0);
    check("R1 shadow src", 64'(active_src), 64'd0);

    // R4 / R6: second burn lands in row 1 and takes priority
    load_shadow(WC);
    pulse_commit();
    strap_fsel = 1'b0;
    settle();
    check("R4 valid both", 64'(row_valid), 64'd3);
    check("R6 row1 src", 64'(active_src), 64'd2);
    check("R6 row1 word", 64'(out_word()), 64'(WC));
    strap_fsel = 1'b1;
    row_sel    = 1'b0;
    settle();
    check("R8 alt row0", 64'(out_word()), 64'(WA));
    row_sel = 1'b1;
    settle();
    check("R8 alt row1", 64'(out_word()), 64'(WC));

    // R5: commit with no blank row
    load_shadow(WD);
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    check("R5 err pulse", 64'(burn_err), 64'd1);
    @(negedge clk);
    check("R5 err cleared", 64'(burn_err), 64'd0);
    settle();
    check("R5 row1 unchanged", 64'(out_word()), 64'(WC));
    row_sel = 1'b0;
    settle();
    check("R5 row0 unchanged", 64'(out_word()), 64'(WA));
    strap_fsel = 1'b0;
    strap_no_shadow = 1'b1;
    settle();
    check("R6 row1 no shadow", 64'(active_src), 64'd2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule